// File: doc/BRIEF.md
# Configuration Register Slave on a Two-Wire Serial Bus

This block lets an external bus controller read and write a bank of byte-wide configuration registers over a two-wire serial bus that follows the I2C protocol. The controller always supplies the clock. The block samples both bus lines with a much faster system clock. It synchronizes each line, removes short glitches, and then finds start conditions, stop conditions and clock edges. It only drives the data line low, and only through an enable, so the line stays open-drain.

A write transaction starts with the address byte. The next byte loads the register pointer, and every further byte is stored at the pointer. A read transaction, usually reached through a repeated start, returns the register at the pointer and continues for as long as the controller acknowledges. After each byte the pointer moves on to the next register. One control bit inside the bank freezes the pointer, so that a stream of bytes can target a single register. The whole bank is also presented in parallel to the logic that uses the settings.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset, every register reads 0x00, the pointer is 0, and the data line is released (`sda_oe` = 0).
- R2: The block acknowledges only the address bytes 0x68 (write) and 0x69 (read), which is 7-bit address 0x34 with the direction bit in bit 0. For any other address it stays silent and ignores the bytes that follow until the next start.
- R3: In a write transaction, the first byte after the address is loaded into the pointer. Every following byte is stored in the register at the pointer. The block acknowledges every one of these bytes.
- R4: When bit 2 of register 0x0C is 0, the pointer advances by one after each data byte written.
- R5: When bit 2 of register 0x0C is 1, the pointer stays where it is, so repeated writes and reads all use the same register. The hold decision for a byte uses the value that bit had before that byte was stored.
- R6: In a read transaction, the block shifts out the register at the pointer, most significant bit first. It changes its drive of the data line only while the clock is low. An acknowledge from the controller continues with the next byte. A not-acknowledge ends the transfer and releases the line.
- R7: Advancing the pointer from 30, or from any higher value, gives 0. This applies to both reads and writes.
- R8: Writes while the pointer is 31 or above are acknowledged but change no register. Reads at such a pointer return 0x00.
- R9: A stop condition returns the block to idle even in the middle of a byte, and a partial byte is discarded. A repeated start begins a new address phase. The pointer is kept across transactions.
- R10: A pulse on the clock line shorter than three system-clock samples is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls the data line low |
| cfg_flat | output | NUM_REGS*8 | All registers side by side, register n at bits [8n+7:8n] |

## Verification
The bench checks that no address other than 0x34 is acknowledged. A decoder that checked too few bits would acknowledge some of them, and data sent after a foreign address would then corrupt the bank. It writes bursts that run past register 30 and reads that cross the same boundary. A wrong wrap would either drop the bytes or spill them into the wrong registers. It sets and clears the hold bit through the bus itself, which exposes any off-by-one in when the new bit takes effect. It also stops a transaction mid-byte, writes to unimplemented addresses, and glitches the clock during a data bit. A design that got these wrong would commit a partial byte, alter a real register, or shift in a spurious bit.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RX_ACK,
      ST_TX,
      ST_TX_ACK
   } i2c_state_e;

   typedef enum logic [1:0] {
      BK_ADDR,
      BK_PTR,
      BK_DATA
   } byte_kind_e;

   localparam int PTR_W = 8;

endpackage

// File: rtl/i2c_pin_filter.sv
module i2c_pin_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic level_o
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 1) begin : g_bad_filt
      $error("FILT_LEN must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
   end

   if (FILT_LEN == 1) begin : g_nofilt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) level_q <= 1'b1;
         else        level_q <= sync_q[SYNC_STAGES-1];
      end
   end else begin : g_window
      logic [FILT_LEN-1:0] win_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            win_q   <= '1;
            level_q <= 1'b1;
         end else begin
            win_q <= {win_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
            if (&win_q)       level_q <= 1'b1;
            else if (~|win_q) level_q <= 1'b0;
         end
      end
   end

   assign level_o = level_q;

endmodule

// File: rtl/i2c_cfg_bank.sv
module i2c_cfg_bank
   import cfg_i2c_pkg::*;
#(
   parameter int NUM_REGS = 31,
   parameter int INC_REG  = 12,
   parameter int INC_BIT  = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [PTR_W-1:0]      addr,
   input  logic [7:0]            wdata,
   output logic [7:0]            rd_data,
   output logic                  hold_o,
   output logic [NUM_REGS*8-1:0] regs_flat
);

   if (NUM_REGS < 1 || NUM_REGS > 256) begin : g_bad_depth
      $error("NUM_REGS must be within 1..256");
   end
   if (INC_REG >= NUM_REGS || INC_BIT > 7) begin : g_bad_ctrl
      $error("hold bit must lie inside the bank");
   end

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [7:0] r_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          r_q <= 8'h00;
         else if (wr_en && addr == PTR_W'(g)) r_q <= wdata;
      end
      assign regs_flat[g*8 +: 8] = r_q;
   end

   always_comb begin
      rd_data = 8'h00;
      for (int i = 0; i < NUM_REGS; i++)
         if (addr == PTR_W'(i)) rd_data = regs_flat[i*8 +: 8];
   end

   assign hold_o = regs_flat[INC_REG*8 + INC_BIT];

   AST_WR_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr >= PTR_W'(NUM_REGS)) |=> $stable(regs_flat)); // R8

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
   import cfg_i2c_pkg::*;
#(
   parameter int         NUM_REGS = 31,
   parameter logic [6:0] DEV_ADDR = 7'h34
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_f,
   input  logic             sda_f,
   input  logic [7:0]       rd_byte,
   input  logic             hold_i,
   output logic             wr_en,
   output logic [PTR_W-1:0] ptr_o,
   output logic [7:0]       wr_data,
   output logic             sda_oe
);

   localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

   i2c_state_e       state_q;
   byte_kind_e       kind_q;
   logic [3:0]       bitcnt_q;
   logic [7:0]       sh_q;
   logic [7:0]       tx_q;
   logic [PTR_W-1:0] ptr_q;
   logic             rd_mode_q;
   logic             more_q;
   logic             scl_p, sda_p;

   logic start_ev, stop_ev, scl_rise, scl_fall;
   logic [PTR_W-1:0] ptr_nxt;

   assign start_ev = scl_f & scl_p & sda_p & ~sda_f;
   assign stop_ev  = scl_f & scl_p & ~sda_p & sda_f;
   assign scl_rise = scl_f & ~scl_p;
   assign scl_fall = ~scl_f & scl_p;
   assign ptr_nxt  = (ptr_q >= LAST) ? '0 : ptr_q + PTR_W'(1);

   assign wr_en   = (state_q == ST_RX) && (kind_q == BK_DATA) && (bitcnt_q == 4'd8) && scl_fall;
   assign wr_data = sh_q;
   assign ptr_o   = ptr_q;
   assign sda_oe  = (state_q == ST_RX_ACK) || ((state_q == ST_TX) && !tx_q[7]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_f;
         sda_p <= sda_f;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         kind_q    <= BK_ADDR;
         bitcnt_q  <= '0;
         sh_q      <= '0;
         tx_q      <= '1;
         ptr_q     <= '0;
         rd_mode_q <= 1'b0;
         more_q    <= 1'b0;
      end else if (start_ev) begin
         state_q  <= ST_RX;
         kind_q   <= BK_ADDR;
         bitcnt_q <= '0;
      end else if (stop_ev) begin
         state_q <= ST_IDLE;
      end else begin
         unique case (state_q)
            ST_RX: begin
               if (scl_rise && bitcnt_q < 4'd8) begin
                  sh_q     <= {sh_q[6:0], sda_f};
                  bitcnt_q <= bitcnt_q + 4'd1;
               end else if (scl_fall && bitcnt_q == 4'd8) begin
                  bitcnt_q <= '0;
                  unique case (kind_q)
                     BK_ADDR: begin
                        rd_mode_q <= sh_q[0];
                        state_q   <= (sh_q[7:1] == DEV_ADDR) ? ST_RX_ACK : ST_IDLE;
                     end
                     BK_PTR: begin
                        ptr_q   <= sh_q;
                        state_q <= ST_RX_ACK;
                     end
                     default: begin
                        if (!hold_i) ptr_q <= ptr_nxt;
                        state_q <= ST_RX_ACK;
                     end
                  endcase
               end
            end
            ST_RX_ACK: begin
               if (scl_fall) begin
                  bitcnt_q <= '0;
                  if (kind_q == BK_ADDR && rd_mode_q) begin
                     state_q <= ST_TX;
                     tx_q    <= rd_byte;
                  end else begin
                     state_q <= ST_RX;
                     kind_q  <= (kind_q == BK_ADDR) ? BK_PTR : BK_DATA;
                  end
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (bitcnt_q == 4'd7) begin
                     state_q <= ST_TX_ACK;
                     tx_q    <= '1;
                  end else begin
                     tx_q     <= {tx_q[6:0], 1'b1};
                     bitcnt_q <= bitcnt_q + 4'd1;
                  end
               end
            end
            ST_TX_ACK: begin
               if (scl_rise) begin
                  more_q <= ~sda_f;
                  if (!hold_i) ptr_q <= ptr_nxt;
               end else if (scl_fall) begin
                  bitcnt_q <= '0;
                  if (more_q) begin
                     state_q <= ST_TX;
                     tx_q    <= rd_byte;
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> (state_q == ST_RX && kind_q == BK_ADDR && bitcnt_q == 4'd0)); // R9
   AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> (state_q == ST_IDLE)); // R9
   AST_SDA_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_f && $past(scl_f) && !$past(start_ev || stop_ev)) |-> $stable(sda_oe)); // R6
   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hold_i) |=> $stable(ptr_q)); // R5
   AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !hold_i && ptr_q >= LAST) |=> (ptr_q == '0)); // R7
   AST_FOREIGN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RX && kind_q == BK_ADDR && bitcnt_q == 4'd8 && scl_fall
       && sh_q[7:1] != DEV_ADDR) |=> !sda_oe); // R2

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
   import cfg_i2c_pkg::*;
#(
   parameter int         NUM_REGS    = 31,
   parameter logic [6:0] DEV_ADDR    = 7'h34,
   parameter int         INC_REG     = 12,
   parameter int         INC_BIT     = 2,
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_LEN    = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_oe,
   output logic [NUM_REGS*8-1:0] cfg_flat
);

   logic             scl_f, sda_f;
   logic             wr_en, hold;
   logic [PTR_W-1:0] ptr;
   logic [7:0]       wr_data, rd_byte;

   i2c_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_filt (
      .clk(clk), .rst_n(rst_n), .pin_i(scl_i), .level_o(scl_f));

   i2c_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_filt (
      .clk(clk), .rst_n(rst_n), .pin_i(sda_i), .level_o(sda_f));

   i2c_byte_engine #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_engine (
      .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
      .rd_byte(rd_byte), .hold_i(hold), .wr_en(wr_en), .ptr_o(ptr),
      .wr_data(wr_data), .sda_oe(sda_oe));

   i2c_cfg_bank #(.NUM_REGS(NUM_REGS), .INC_REG(INC_REG), .INC_BIT(INC_BIT)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(ptr), .wdata(wr_data),
      .rd_data(rd_byte), .hold_o(hold), .regs_flat(cfg_flat));

endmodule

// File: tb/cfg_i2c_slave_tb_top.sv
module cfg_i2c_slave_tb_top;

   localparam int Q = 10;
   localparam int NR = 31;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   logic [NR*8-1:0] cfg_flat;
   wire  sda_line = sda_m & ~sda_oe;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;
   logic [7:0] mdl [NR];
   int mptr = 0;
   logic [7:0] wbuf [64];

   always #5 clk = ~clk;

   cfg_i2c_slave dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .cfg_flat(cfg_flat));

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic chk_bank(input string req);
      int bad = -1;
      n_chk++;
      for (int i = 0; i < NR; i++)
         if (bad < 0 && cfg_flat[i*8 +: 8] !== mdl[i]) bad = i;
      if (bad >= 0) begin
         n_err++;
         $display("FAIL %s reg %0d act=%h exp=%h", req, bad, cfg_flat[bad*8 +: 8], mdl[bad]);
      end
   endtask

   function automatic int m_next(input int p);
      return (p >= NR - 1) ? 0 : p + 1;
   endfunction

   task automatic m_write(input logic [7:0] b);
      bit h = mdl[12][2];
      if (mptr < NR) mdl[mptr] = b;
      if (!h) mptr = m_next(mptr);
   endtask

   task automatic m_read(output logic [7:0] v);
      v = (mptr < NR) ? mdl[mptr] : 8'h00;
      if (!mdl[12][2]) mptr = m_next(mptr);
   endtask

   task automatic bstart();
      tick(2); sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0;
   endtask

   task automatic bstop();
      tick(2); sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(2*Q);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
      for (int i = 0; i < n; i++) begin
         tick(2); sda_m = b[7-i];
         if (glitch && i == 3) begin
            tick(3); scl_m = 1'b1; tick(1); scl_m = 1'b0; tick(Q-6);
         end else begin
            tick(Q-2);
         end
         scl_m = 1'b1; tick(Q);
         scl_m = 1'b0;
      end
   endtask

   task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
      send_bits(b, 8, glitch);
      tick(2); sda_m = 1'b1; tick(Q-2);
      scl_m = 1'b1; tick(Q/2);
      ack = ~sda_line;
      tick(Q/2);
      scl_m = 1'b0;
   endtask

   task automatic recv_byte(input bit mack, output logic [7:0] b);
      sda_m = 1'b1;
      b = '0;
      for (int i = 0; i < 8; i++) begin
         tick(Q); scl_m = 1'b1; tick(Q/2);
         b = {b[6:0], sda_line};
         tick(Q/2); scl_m = 1'b0;
      end
      tick(2); sda_m = ~mack; tick(Q-2);
      scl_m = 1'b1; tick(Q);
      scl_m = 1'b0; tick(2);
      sda_m = 1'b1;
   endtask

   task automatic wr_txn(input logic [7:0] p, input int n, input bit glitch, input string req);
      bit a;
      bstart();
      send_byte(8'h68, 1'b0, a); chk8({req, " addr ack"}, 8'(a), 8'h01);
      send_byte(p, 1'b0, a);     chk8({req, " ptr ack"}, 8'(a), 8'h01);
      mptr = p;
      for (int i = 0; i < n; i++) begin
         send_byte(wbuf[i], glitch, a);
         m_write(wbuf[i]);
         chk8({req, " data ack"}, 8'(a), 8'h01);
      end
      bstop();
   endtask

   task automatic rd_at(input logic [7:0] p, input int n, input string req);
      bit a;
      logic [7:0] got, exp;
      bstart();
      send_byte(8'h68, 1'b0, a); chk8({req, " addr ack"}, 8'(a), 8'h01);
      send_byte(p, 1'b0, a);     chk8({req, " ptr ack"}, 8'(a), 8'h01);
      mptr = p;
      bstart();   // repeated start, R9
      send_byte(8'h69, 1'b0, a); chk8({req, " R9 read addr ack"}, 8'(a), 8'h01);
      for (int i = 0; i < n; i++) begin
         recv_byte(i < n - 1, got);
         m_read(exp);
         chk8({req, " read data"}, got, exp);
      end
      tick(3);
      chk8({req, " R6 released after nack"}, 8'(sda_oe), 8'h00);
      bstop();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      bit a;
      for (int i = 0; i < NR; i++) mdl[i] = 8'h00;
      tick(5); rst_n = 1'b1; tick(5);

      // R1: reset state
      chk_bank("R1 reset bank");
      chk8("R1 sda released", 8'(sda_oe), 8'h00);

      // R2: every foreign address is left unacknowledged
      for (int ad = 0; ad < 128; ad++) begin
         if (ad != 8'h34) begin
            bstart();
            send_byte({7'(ad), 1'b0}, 1'b0, a);
            chk8("R2 foreign address nack", 8'(a), 8'h00);
            bstop();
         end
      end
      // R2: bytes after a foreign address leave the bank alone
      bstart();
      send_byte(8'h6A, 1'b0, a);
      send_byte(8'h00, 1'b0, a);
      send_byte(8'h99, 1'b0, a);
      bstop();
      chk_bank("R2 foreign write ignored");

      // R3 R4 R7: burst from 0 that runs past the last register
      for (int i = 0; i < 33; i++) wbuf[i] = 8'((i * 37 + 5) & 255);
      wr_txn(8'd0, 33, 1'b0, "R4");
      chk_bank("R3 R4 R7 burst write");

      // R6: read the whole bank back
      rd_at(8'd0, NR, "R6");
      // R7: read across the wrap
      rd_at(8'd29, 4, "R7");

      // R7: write across the wrap
      for (int i = 0; i < 5; i++) wbuf[i] = 8'(8'hE0 + i);
      wr_txn(8'd28, 5, 1'b0, "R7");
      chk_bank("R7 write wrap");

      // R5: set hold bit, then repeated writes and reads hit one register
      wbuf[0] = 8'h04;
      wr_txn(8'd12, 1, 1'b0, "R5");
      wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
      wr_txn(8'd5, 3, 1'b0, "R5");
      chk_bank("R5 hold write");
      rd_at(8'd5, 3, "R5");
      wbuf[0] = 8'h00;
      wr_txn(8'd12, 1, 1'b0, "R5");
      chk_bank("R5 hold cleared");

      // R8: unimplemented addresses
      wbuf[0] = 8'h55;
      wr_txn(8'd40, 1, 1'b0, "R8");
      chk_bank("R8 discard write");
      rd_at(8'd200, 2, "R8");

      // R9: stop in the middle of a data byte
      bstart();
      send_byte(8'h68, 1'b0, a);
      send_byte(8'd3, 1'b0, a);
      send_bits(8'h5A, 4, 1'b0);
      bstop();
      mptr = 3;
      chk_bank("R9 partial byte dropped");
      bstart();
      send_byte(8'h68, 1'b0, a);
      chk8("R9 accepted after stop", 8'(a), 8'h01);
      bstop();

      // R10: clock glitch during a data bit
      wbuf[0] = 8'h3C;
      wr_txn(8'd7, 1, 1'b1, "R10");
      chk_bank("R10 glitch ignored");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule